// File: doc/BRIEF.md
# Multi-Format Pixel Write Assembler

This block sits between a host write port and display memory. The host sends data on either an 8-bit or a 16-bit bus. The block gathers one, two or three of these writes into one pixel and hands that pixel on as an 18-bit RGB word, together with a single-clock write strobe. Two configuration inputs choose how the data is packed. One picks the bus width. The other picks the colour packing: 4-4-4, 5-6-5 or truncated 6-6-6. The block counts how far through a pixel's sequence the host is, and it discards the dummy bits. Components narrower than 6 bits are widened by copying their top bits into the vacated low bits.

The write sequence returns to its first step in four cases: after each committed pixel, on a command write, on any change of configuration, and when chip select is released. Display memory therefore only ever sees whole pixels. The memory array itself, the address counters and command decoding are handled elsewhere.

Top module: `pixel_assembler`

## Requirements
- R1: While reset is held and on the first cycle after it, `pixStb` is 0 and `pixOut` is 0. The first accepted write is treated as step one of a pixel.
- R2: With `colorFmt`=2'b00 (4-4-4) and `busWide`=1, a single write commits a pixel. Red is D15..D12, green D11..D8 and blue D7..D4, and D3..D0 have no effect. A 4-bit component c becomes {c, c[3:2]}.
- R3: With `colorFmt`=2'b01 (5-6-5) and `busWide`=0, two writes make one pixel. Write one carries R[4:0] in D7..D3 and G[5:3] in D2..D0. Write two carries G[2:0] in D7..D5 and B[4:0] in D4..D0. A 5-bit component c becomes {c, c[4]}. Write one raises no strobe.
- R4: With `colorFmt`=2'b01 and `busWide`=1, a single write commits a pixel with R in D15..D11, G in D10..D5 and B in D4..D0.
- R5: With `colorFmt`=2'b10 or 2'b11 (6-6-6) and `busWide`=0, three writes carry red, then green, then blue, each in D7..D2. D1..D0 have no effect. Only the third write raises the strobe.
- R6: With 6-6-6 and `busWide`=1, two writes make one pixel. Write one carries R in D15..D10 and G in D7..D2. Write two carries B in D15..D10. All other bits have no effect, and write one raises no strobe.
- R7: `pixStb` is high for exactly the one clock that follows the edge that took in a pixel's final write, and `pixOut` = {R[5:0], G[5:0], B[5:0]} holds that pixel on the same clock. Final writes on consecutive cycles give strobes on consecutive cycles.
- R8: A write with `isCmd`=1 produces no pixel and returns the sequence to step one.
- R9: Writes while `csN`=1 are ignored. A rising edge on `csN` returns the sequence to step one.
- R10: A change of `colorFmt` or `busWide` returns the sequence to step one. A write on the same clock as the change counts as step one of the new configuration.
- R11: With `colorFmt`=2'b00 and `busWide`=0, data writes are ignored and produce no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Host write strobe, one write per high cycle |
| isCmd | input | 1 | 1 marks the write as a command rather than pixel data |
| csN | input | 1 | Active-low chip select |
| busWide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus (lanes D7..D0) |
| colorFmt | input | 2 | 00 = 4-4-4, 01 = 5-6-5, 10/11 = truncated 6-6-6 |
| dataIn | input | 16 | Host data bus |
| pixOut | output | 18 | Assembled pixel {R, G, B}, 6 bits each |
| pixStb | output | 1 | One-clock memory write strobe for `pixOut` |

## Verification
A configuration change can arrive on the same clock as a data write. In that case the phase clear and the step-one capture both act on that clock. The bench provokes this by starting a two-write 5-6-5 narrow sequence and then switching to 5-6-5 wide at the very moment the next write is driven. The clear must win over the stale partial pixel, and the write must still count. So the strobe must rise on the following clock, carrying only the fields of that wide write. The bench also drives final writes on consecutive cycles, which checks that the phase returns to step one without costing an idle cycle.

// File: rtl/pa_pkg.sv
package pa_pkg;
  localparam int DATA_W = 16;
  localparam int COMP_W = 6;
  localparam int PIX_W  = 3 * COMP_W;
  localparam int PHASE_W = 2;

  typedef enum logic [1:0] {
    FMT_444    = 2'b00,
    FMT_565    = 2'b01,
    FMT_666    = 2'b10,
    FMT_666ALT = 2'b11
  } fmt_e;

  typedef struct packed {
    logic keepFirst;
    logic keepSecond;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/pa_ctrl.sv
module pa_ctrl
  import pa_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStb,
  input  logic    isCmd,
  input  logic    csN,
  input  logic    busWide,
  input  fmt_e    fmt,
  output strobe_t stb
);
  logic [PHASE_W-1:0] phase, phaseNext, effPhase, lastIdx;
  logic [2:0] modeQ;
  logic       csNq;
  logic       modeChg, csRise, fmtOk, accept, cmdHit, isLast;

  always_comb begin
    unique case (fmt)
      FMT_444: lastIdx = 2'd0;
      FMT_565: lastIdx = busWide ? 2'd0 : 2'd1;
      default: lastIdx = busWide ? 2'd1 : 2'd2;
    endcase
  end

  assign modeChg  = ({busWide, fmt} != modeQ);
  assign csRise   = csN & ~csNq;
  assign fmtOk    = !(fmt == FMT_444 && !busWide);
  assign accept   = wrStb & ~csN & ~isCmd & fmtOk;
  assign cmdHit   = wrStb & ~csN & isCmd;
  assign effPhase = modeChg ? '0 : phase;
  assign isLast   = accept && (effPhase == lastIdx);

  always_comb begin
    if (csRise || cmdHit)  phaseNext = '0;
    else if (accept)       phaseNext = isLast ? '0 : effPhase + 1'b1;
    else                   phaseNext = effPhase;
  end

  assign stb.keepFirst  = accept && !isLast && (effPhase == 2'd0);
  assign stb.keepSecond = accept && !isLast && (effPhase == 2'd1);
  assign stb.commit     = isLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      modeQ <= {1'b0, FMT_565};
      csNq  <= 1'b1;
    end else begin
      phase <= phaseNext;
      modeQ <= {busWide, fmt};
      csNq  <= csN;
    end
  end
endmodule

// File: rtl/pa_datapath.sv
module pa_datapath
  import pa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              busWide,
  input  fmt_e              fmt,
  input  logic [DATA_W-1:0] dataIn,
  output logic [PIX_W-1:0]  pixOut,
  output logic              pixStb
);
  logic [13:0]        holdA;
  logic [COMP_W-1:0]  holdB;
  logic [COMP_W-1:0]  redC, grnC, bluC;
  logic [5:0]         holdAHi;
  logic [7:0]         holdALo;

  assign holdAHi = holdA[13:8];
  assign holdALo = holdA[7:0];

  function automatic logic [COMP_W-1:0] widen4(input logic [3:0] c);
    return {c, c[3:2]};
  endfunction

  function automatic logic [COMP_W-1:0] widen5(input logic [4:0] c);
    return {c, c[4]};
  endfunction

  always_comb begin
    unique case (fmt)
      FMT_444: begin
        redC = widen4(dataIn[15:12]);
        grnC = widen4(dataIn[11:8]);
        bluC = widen4(dataIn[7:4]);
      end
      FMT_565: begin
        if (busWide) begin
          redC = widen5(dataIn[15:11]);
          grnC = dataIn[10:5];
        end else begin
          redC = widen5(holdALo[7:3]);
          grnC = {holdALo[2:0], dataIn[7:5]};
        end
        bluC = widen5(dataIn[4:0]);
      end
      default: begin
        if (busWide) begin
          redC = holdAHi;
          grnC = holdALo[7:2];
          bluC = dataIn[15:10];
        end else begin
          redC = holdALo[7:2];
          grnC = holdB;
          bluC = dataIn[7:2];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdA  <= '0;
      holdB  <= '0;
      pixOut <= '0;
      pixStb <= 1'b0;
    end else begin
      if (stb.keepFirst)  holdA <= {dataIn[15:10], dataIn[7:0]};
      if (stb.keepSecond) holdB <= dataIn[7:2];
      if (stb.commit)     pixOut <= {redC, grnC, bluC};
      pixStb <= stb.commit;
    end
  end
endmodule

// File: rtl/pixel_assembler.sv
module pixel_assembler
  import pa_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic        isCmd,
  input  logic        csN,
  input  logic        busWide,
  input  logic [1:0]  colorFmt,
  input  logic [15:0] dataIn,
  output logic [17:0] pixOut,
  output logic        pixStb
);
  strobe_t stb;
  fmt_e    fmt;

  assign fmt = fmt_e'(colorFmt);

  pa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .isCmd(isCmd), .csN(csN),
    .busWide(busWide), .fmt(fmt), .stb(stb)
  );

  pa_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWide(busWide), .fmt(fmt),
    .dataIn(dataIn), .pixOut(pixOut), .pixStb(pixStb)
  );
endmodule

// File: rtl/pa_checker.sv
module pa_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrStb,
  input logic        isCmd,
  input logic        csN,
  input logic        busWide,
  input logic [1:0]  colorFmt,
  input logic [15:0] dataIn,
  input logic [17:0] pixOut,
  input logic        pixStb
);
  // R7: a strobe always follows an accepted data write
  a_r7_strobe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    pixStb |-> $past(wrStb && !csN && !isCmd));

  // R8: a command write never yields a pixel
  a_r8_cmd_no_pixel: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && isCmd) |=> !pixStb);

  // R9: deselected writes never yield a pixel
  a_r9_cs_blocks: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !pixStb);

  // R11: 4-4-4 on the narrow bus never yields a pixel
  a_r11_narrow444_idle: assert property (@(posedge clk) disable iff (!rstN)
    (colorFmt == 2'b00 && !busWide) |=> !pixStb);

  // R4: a wide 5-6-5 data write commits the pixel on the next clock
  a_r4_wide565_commit: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && !csN && !isCmd && busWide && colorFmt == 2'b01) |=>
      (pixStb && pixOut == {$past(dataIn[15:11]), $past(dataIn[15]),
                            $past(dataIn[10:5]),
                            $past(dataIn[4:0]), $past(dataIn[4])}));

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!pixStb && pixOut == 18'd0));
endmodule

bind pixel_assembler pa_checker u_chk (.*);

// File: tb/tb_pixel_assembler.sv
module tb_pixel_assembler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic        isCmd = 1'b0;
  logic        csN = 1'b1;
  logic        busWide = 1'b0;
  logic [1:0]  colorFmt = 2'b01;
  logic [15:0] dataIn = '0;
  logic [17:0] pixOut;
  logic        pixStb;

  int nChecks = 0;
  int nFails = 0;
  logic        gotStb;
  logic [17:0] gotPix;

  always #2.5 clk = ~clk;

  pixel_assembler dut (.*);

  function automatic logic [5:0] w4(input logic [3:0] c); return {c, c[3:2]}; endfunction
  function automatic logic [5:0] w5(input logic [4:0] c); return {c, c[4]}; endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write cycle; outputs captured just after the taking edge
  task automatic wr(input logic [15:0] d, input logic cmd = 1'b0);
    @(negedge clk);
    wrStb = 1'b1; isCmd = cmd; dataIn = d;
    @(posedge clk); #1;
    gotStb = pixStb; gotPix = pixOut;
  endtask

  task automatic idle(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrStb = 1'b0; isCmd = 1'b0;
    end
  endtask

  task automatic setMode(input logic [1:0] f, input logic w);
    @(negedge clk);
    wrStb = 1'b0; colorFmt = f; busWide = w;
    idle(1);
  endtask

  task automatic tReset();
    @(posedge clk); #1;
    check("R1 stb in reset", pixStb, 0);
    check("R1 pix in reset", pixOut, 0);
    @(negedge clk); rstN = 1'b1; csN = 1'b0;
    @(posedge clk); #1;
    check("R1 stb after reset", pixStb, 0);
    check("R1 pix after reset", pixOut, 0);
  endtask

  task automatic t444Wide();
    setMode(2'b00, 1'b1);
    wr(16'hA5C3);
    check("R2 stb", gotStb, 1);
    check("R2 pix", gotPix, {w4(4'hA), w4(4'h5), w4(4'hC)});
    wr(16'hA5CF);
    check("R2 dummy bits", gotPix, {w4(4'hA), w4(4'h5), w4(4'hC)});
    idle(1);
    @(posedge clk); #1;
    check("R7 one-clock strobe", pixStb, 0);
  endtask

  task automatic t565Narrow();
    setMode(2'b01, 1'b0);
    wr(16'h00B6);               // R=10110, G hi=110
    check("R3 no stb first", gotStb, 0);
    wr(16'h0053);               // G lo=010, B=10011
    check("R3 stb", gotStb, 1);
    check("R3 pix", gotPix, {w5(5'b10110), 6'b110010, w5(5'b10011)});
    idle(1);
  endtask

  task automatic t565Wide();
    setMode(2'b01, 1'b1);
    wr(16'h9D2E);
    check("R4 stb", gotStb, 1);
    check("R4 pix", gotPix, {w5(5'h13), 6'h29, w5(5'h0E)});
    idle(1);
  endtask

  task automatic t666Narrow();
    setMode(2'b10, 1'b0);
    wr(16'h00AB);
    check("R5 no stb red", gotStb, 0);
    wr(16'h0057);
    check("R5 no stb green", gotStb, 0);
    wr(16'h00F2);
    check("R5 stb", gotStb, 1);
    check("R5 pix", gotPix, {6'h2A, 6'h15, 6'h3C});
    idle(1);
  endtask

  task automatic t666Wide();
    setMode(2'b11, 1'b1);
    wr(16'hC3F7);
    check("R6 no stb first", gotStb, 0);
    wr(16'h87FF);
    check("R6 stb", gotStb, 1);
    check("R6 pix", gotPix, {6'h30, 6'h3D, 6'h21});
    idle(1);
  endtask

  task automatic tBackToBack();
    setMode(2'b01, 1'b1);
    wr(16'h1111);
    check("R7 b2b stb 1", gotStb, 1);
    wr(16'hFFFF);
    check("R7 b2b stb 2", gotStb, 1);
    check("R7 b2b pix 2", gotPix, 18'h3FFFF);
    wr(16'h0000);
    check("R7 b2b stb 3", gotStb, 1);
    check("R7 b2b pix 3", gotPix, 18'h0);
    idle(1);
  endtask

  task automatic tCommand();
    setMode(2'b10, 1'b0);
    wr(16'h00FC);
    wr(16'h0004, 1'b1);
    check("R8 cmd no stb", gotStb, 0);
    wr(16'h0004);
    wr(16'h0008);
    check("R8 restarted no stb", gotStb, 0);
    wr(16'h000C);
    check("R8 stb", gotStb, 1);
    check("R8 pix", gotPix, {6'h01, 6'h02, 6'h03});
    idle(1);
  endtask

  task automatic tChipSelect();
    setMode(2'b01, 1'b0);
    wr(16'h00FF);
    idle(1);
    @(negedge clk); csN = 1'b1;
    wr(16'h0000);
    check("R9 deselected no stb", gotStb, 0);
    idle(1);
    @(negedge clk); csN = 1'b0;
    wr(16'h0008);               // R=00001, G hi=000
    check("R9 restart no stb", gotStb, 0);
    wr(16'h0001);
    check("R9 stb", gotStb, 1);
    check("R9 pix", gotPix, {w5(5'b00001), 6'b000000, w5(5'b00001)});
    idle(1);
  endtask

  task automatic tModeChange();
    setMode(2'b01, 1'b0);
    wr(16'h00FF);
    @(negedge clk);
    wrStb = 1'b1; dataIn = 16'h0841; busWide = 1'b1;
    @(posedge clk); #1;
    check("R10 stb on change", pixStb, 1);
    check("R10 pix", pixOut, {w5(5'h01), 6'h02, w5(5'h01)});
    idle(1);
  endtask

  task automatic tNarrow444();
    setMode(2'b00, 1'b0);
    wr(16'hFFFF);
    check("R11 no stb a", gotStb, 0);
    wr(16'h1234);
    check("R11 no stb b", gotStb, 0);
    idle(1);
    @(posedge clk); #1;
    check("R11 no stb c", pixStb, 0);
  endtask

  initial begin
    fork
      begin
        tReset();
        t444Wide();
        t565Narrow();
        t565Wide();
        t666Narrow();
        t666Wide();
        tBackToBack();
        tCommand();
        tChipSelect();
        tModeChange();
        tNarrow444();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule